// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Capture

This block sits between an asynchronous x8 parallel memory bus and the synchronous logic that models or serves the memory. It samples the chip-enable, write-enable and output-enable strobes, along with the address and data buses, using a fast system clock. For every genuine bus write it produces exactly one clean single-cycle event that carries the address and data of that write. Command decoding, the read path and the storage array are the concern of later stages.

A write window is the stretch of time during which chip enable and write enable are both low. The address is taken at the moment the window opens, which is the falling edge of whichever strobe goes low last. The data is taken at the moment the window closes, which is the rising edge of whichever strobe goes high first. Windows shorter than a parameterised number of clock cycles are treated as glitches and dropped. A window that opens while output enable is low is inhibited, and so is any window seen while the power-good input is low.

Internally, a small state machine has three states:
- `ST_IDLE`: no window is open.
- `ST_OPEN`: an accepted window is being timed.
- `ST_BLOCKED`: an inhibited window is waiting to close.

Its transitions are:
- `ST_IDLE`→`ST_OPEN`: a window opens with output enable high and power good.
- `ST_IDLE`→`ST_BLOCKED`: a window opens with output enable low or power not good.
- `ST_OPEN`→`ST_BLOCKED`: power-good drops during the window.
- `ST_OPEN`→`ST_IDLE`: the window closes. An event is emitted if the window was long enough.
- `ST_BLOCKED`→`ST_IDLE`: the window closes. No event is emitted.

Top module: `pflash_wr_capture`

## Requirements
- R1: After reset, `wr_valid`, `wr_addr` and `wr_data` are all zero.
- R2: Each accepted write window produces exactly one `wr_valid` pulse that lasts one cycle. The pulse is high in the third clock cycle after the input edge that closes the window, because there are two synchronizer flops plus one output register.
- R3: `wr_addr` equals the address bus value present when the later of the two strobes fell. Address changes made while only one strobe is low do not affect it.
- R4: `wr_data` equals the data bus value present when the earlier of the two strobes rose. Data changes made after that edge do not affect it.
- R5: With `MIN_LOW_CYC` = 3, a window that lasts 2 synchronized cycles gives no event, and a window that lasts exactly 3 cycles gives an event.
- R6: If output enable is low when a window opens, no event is produced for that window. If output enable goes low only after the window opened, the write is still accepted.
- R7: If power-good is low when a window opens, or falls at any point inside the window, no event is produced for that window.
- R8: `wr_addr` and `wr_data` hold their values in every cycle in which `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | High when supply is good. Low suppresses all writes |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_addr | input | ADDR_W (19) | Bus address |
| bus_data | input | DATA_W (8) | Bus data |
| wr_valid | output | 1 | One-cycle write event |
| wr_addr | output | ADDR_W (19) | Captured write address |
| wr_data | output | DATA_W (8) | Captured write data |

## Verification
The bench drives the bus on falling clock edges. A write event is due in the third clock cycle after the edge that drives the closing strobe high. When the driver issues that closing edge, it stamps each expected item with the cycle number in which the event must appear. The monitor samples on falling edges and compares the address, the data and the arrival cycle against that stamp. It also flags any event for which nothing was expected. After every rejected or inhibited window, the bench waits more than the full latency before it confirms that no event arrived and that the held outputs are unchanged.

// File: rtl/pfwc_pkg.sv
package pfwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OPEN    = 2'd1,
        ST_BLOCKED = 2'd2
    } cap_state_t;
endpackage

// File: rtl/pfwc_sync.sv
module pfwc_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pfwc_fsm.sv
module pfwc_fsm
    import pfwc_pkg::*;
#(
    parameter int AW          = 19,
    parameter int DW          = 8,
    parameter int MIN_LOW_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          win,
    input  logic          oe_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int            CW      = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] MIN_CNT = CW'(MIN_LOW_CYC);
    localparam logic [CW-1:0] ONE_CNT = CW'(1);

    cap_state_t    state, nxt;
    logic [CW-1:0] low_cnt;
    logic [AW-1:0] addr_lat;
    logic          inhibit;
    logic          accept;
    logic          emit;

    assign inhibit = !oe_s || !pwr_good;
    assign accept  = (state == ST_IDLE) && win && !inhibit;
    assign emit    = (state == ST_OPEN) && pwr_good && !win && (low_cnt >= MIN_CNT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (win) nxt = inhibit ? ST_BLOCKED : ST_OPEN;
            ST_OPEN: begin
                if (!pwr_good)  nxt = ST_BLOCKED;
                else if (!win)  nxt = ST_IDLE;
            end
            ST_BLOCKED: if (!win) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            addr_lat <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (accept) begin
                addr_lat <= addr_s;
                low_cnt  <= ONE_CNT;
            end else if (state == ST_OPEN && win && low_cnt < MIN_CNT) begin
                low_cnt  <= low_cnt + ONE_CNT;
            end
            if (emit) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr_lat;
                wr_data  <= data_s;
            end
        end
    end
endmodule

// File: rtl/pflash_wr_capture.sv
module pflash_wr_capture #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int MIN_LOW_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [2:0]        strb_s;
    logic [BUS_W-1:0]  bus_s;
    logic              win_s;

    pfwc_sync #(.W(3), .RST_VAL(3'b111)) u_strb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n}),
        .q     (strb_s)
    );

    pfwc_sync #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_addr, bus_data}),
        .q     (bus_s)
    );

    assign win_s = !strb_s[2] && !strb_s[1];

    pfwc_fsm #(.AW(ADDR_W), .DW(DATA_W), .MIN_LOW_CYC(MIN_LOW_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .win      (win_s),
        .oe_s     (strb_s[0]),
        .addr_s   (bus_s[BUS_W-1:DATA_W]),
        .data_s   (bus_s[DATA_W-1:0]),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );
endmodule

// File: rtl/pfwc_checker.sv
module pfwc_checker #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          win,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data
);
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_close_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(win, 2) && !$past(win)));

    assert_power_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(pwr_good));

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> $stable(wr_addr));

    assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> $stable(wr_data));
endmodule

bind pflash_wr_capture pfwc_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .win      (win_s),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/pflash_wr_capture_tb.sv
module pflash_wr_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        wr_valid;
    logic [18:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [18:0] a;
        logic [7:0]  d;
        int          due;
        string       req;
    } exp_t;
    exp_t q[$];
    logic [18:0] last_a = '0;
    logic [7:0]  last_d = '0;

    pflash_wr_capture u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (q.size() == 0) begin
                check(0, "R2 unexpected event", int'(wr_addr), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(wr_addr == e.a, {e.req, " addr"}, int'(wr_addr), int'(e.a));
                check(wr_data == e.d, {e.req, " data"}, int'(wr_data), int'(e.d));
                check(cyc == e.due, "R2 latency", cyc, e.due);
                last_a = e.a;
                last_d = e.d;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // call at the negedge that drives the closing strobe high
    task automatic expect_ev(logic [18:0] a, logic [7:0] d, string req);
        exp_t e;
        e.a = a; e.d = d; e.due = cyc + 3; e.req = req;
        q.push_back(e);
    endtask

    task automatic settle(string req);
        tick(6);
        check(q.size() == 0, {req, " missing event"}, q.size(), 0);
        check(wr_addr == last_a && wr_data == last_d, {req, " R8 hold"},
              int'({wr_addr, wr_data}), int'({last_a, last_d}));
    endtask

    task automatic plain_write(logic [18:0] a, logic [7:0] d, int low, bit exp, string req);
        bus_addr = a; bus_data = d; ce_n = 0; we_n = 0;
        tick(low);
        ce_n = 1; we_n = 1;
        if (exp) expect_ev(a, d, req);
        settle(req);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        check(wr_valid == 0, "R1 valid", int'(wr_valid), 0);
        check(wr_addr == 0, "R1 addr", int'(wr_addr), 0);
        check(wr_data == 0, "R1 data", int'(wr_data), 0);

        // R2 basic and several patterns
        plain_write(19'h05555, 8'hAA, 4, 1, "R2");
        for (int i = 0; i < 4; i++)
            plain_write(19'h7FFFF ^ (19'(i) << (i * 4)), 8'(8'h3C + i * 37), 3 + i, 1, "R2 pattern");

        // R5 glitch threshold
        plain_write(19'h01234, 8'h11, 2, 0, "R5 short");
        plain_write(19'h04321, 8'h22, 1, 0, "R5 shorter");
        plain_write(19'h02AAA, 8'h33, 3, 1, "R5 exact");

        // R3 CE first, address changes before WE falls
        bus_addr = 19'h11111; bus_data = 8'h44; ce_n = 0;
        tick(2);
        bus_addr = 19'h22222; we_n = 0;
        tick(4);
        bus_addr = 19'h33333; tick(1);
        we_n = 1; ce_n = 1;
        expect_ev(19'h22222, 8'h44, "R3 ce first");
        settle("R3");

        // R3 WE first
        bus_addr = 19'h0AAAA; bus_data = 8'h55; we_n = 0;
        tick(3);
        bus_addr = 19'h05A5A; ce_n = 0;
        tick(4);
        we_n = 1; ce_n = 1;
        expect_ev(19'h05A5A, 8'h55, "R3 we first");
        settle("R3b");

        // R4 WE rises first, data changes before CE rises
        bus_addr = 19'h12345; bus_data = 8'h66; ce_n = 0; we_n = 0;
        tick(4);
        we_n = 1;
        expect_ev(19'h12345, 8'h66, "R4 we rises first");
        tick(1);
        bus_data = 8'h99;
        tick(2);
        ce_n = 1;
        settle("R4");

        // R4 CE rises first
        bus_addr = 19'h54321; bus_data = 8'h77; ce_n = 0; we_n = 0;
        tick(4);
        ce_n = 1;
        expect_ev(19'h54321, 8'h77, "R4 ce rises first");
        tick(1);
        bus_data = 8'h88;
        tick(2);
        we_n = 1;
        settle("R4b");

        // R6 OE low at open: inhibited
        oe_n = 0;
        plain_write(19'h00F0F, 8'hDE, 5, 0, "R6 oe low");
        oe_n = 1;
        tick(2);
        // R6 OE low only after opening: accepted
        bus_addr = 19'h0F0F0; bus_data = 8'hAD; ce_n = 0; we_n = 0;
        tick(3);
        oe_n = 0;
        tick(2);
        ce_n = 1; we_n = 1;
        expect_ev(19'h0F0F0, 8'hAD, "R6 late oe");
        tick(1);
        oe_n = 1;
        settle("R6b");

        // R7 power low across window
        pwr_good = 0;
        plain_write(19'h03C3C, 8'hBE, 5, 0, "R7 power low");
        pwr_good = 1;
        // R7 power drop inside window
        bus_addr = 19'h0C3C3; bus_data = 8'hEF; ce_n = 0; we_n = 0;
        tick(4);
        pwr_good = 0;
        tick(1);
        pwr_good = 1;
        tick(2);
        ce_n = 1; we_n = 1;
        settle("R7 mid drop");
        // R7 recovery
        plain_write(19'h00001, 8'h01, 4, 1, "R7 recovered");

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                check(0, "watchdog", cyc, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule